// File: doc/BRIEF.md
# Counted Page Override Unit

This unit sits in the data address path of a CPU that splits a 16-bit logical address into a 2-bit page selector and a 14-bit offset. Normally the selector picks one of four 10-bit page registers, and that register forms the top ten bits of a 24-bit physical address. When a page-override instruction issues, the unit captures a 10-bit page and a 2-bit length field. For the next 1 to 4 retired instructions, it places the captured page on the upper address bits for long and indirect accesses.

While the override is running, the unit raises a lock output. The lock holds off ordinary interrupts, peripheral transfer requests and class A traps. The sequence ends by itself when its count runs out. A class B trap ends it at once. The override works from the first instruction after the issuing one, so no delay slots are needed.

Top module: `page_override_unit`

## Requirements
- R1: After reset, `lock` is low and `paddr` is formed from the page registers as in R2.
- R2: Outside a sequence, `paddr[23:14]` equals the page register chosen by `laddr[15:14]` (00 selects `pg_reg0`, 01 `pg_reg1`, 10 `pg_reg2`, 11 `pg_reg3`), and `paddr[13:0]` always equals `laddr[13:0]`.
- R3: An `issue` pulse captures `issue_page` and loads a count of `issue_len`+1 (field 0 gives 1 instruction, 3 gives 4). From the cycle after that edge, `paddr[23:14]` equals the captured page whenever `mode_ext` is 1.
- R4: During a sequence, an access with `mode_ext` at 0 still takes its page from the page registers.
- R5: Each `retire` pulse during a sequence lowers the count by one. After `issue_len`+1 such pulses, the override stops. Cycles without `retire` leave the count unchanged.
- R6: `lock` is high exactly while the count is nonzero and `trap_b` is low.
- R7: While `trap_b` is high, `lock` is low and no override applies, in the same cycle. The count is zero after that edge, and `trap_b` takes priority over an `issue` in the same cycle.
- R8: A `retire` in the same cycle as `issue` belongs to the issuing instruction and does not count. A `retire` outside a sequence has no effect.
- R9: An `issue` during a running sequence replaces its page and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Override instruction issues this cycle |
| issue_page | input | 10 | Page operand |
| issue_len | input | 2 | Length field, value+1 instructions |
| retire | input | 1 | One instruction retires this cycle |
| mode_ext | input | 1 | Current access uses long or indirect addressing |
| laddr | input | 16 | Logical address |
| pg_reg0 | input | 10 | Page register for selector 00 |
| pg_reg1 | input | 10 | Page register for selector 01 |
| pg_reg2 | input | 10 | Page register for selector 10 |
| pg_reg3 | input | 10 | Page register for selector 11 |
| trap_b | input | 1 | Class B trap condition |
| paddr | output | 24 | Physical address |
| lock | output | 1 | Interrupt and class A trap lock |

## Verification
The assertions assume the pipeline raises `retire` at most once per cycle, and never while the issuing instruction itself is still in flight apart from the issue cycle. They also assume that `trap_b`, `issue` and `retire` are clean single-cycle levels sampled at the clock edge. The stimulus changes inputs only just after a rising edge. It runs every length field against several pages and all four selector values. It pairs each `retire` with one instruction, and it sets up the overlapping cases (trap with issue, retire with issue, reissue) one at a time.

// File: rtl/page_override_unit.sv
module page_override_unit #(
  parameter int PW = 10,
  parameter int AW = 16,
  parameter int CW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [PW-1:0]    issue_page,
  input  logic [CW-1:0]    issue_len,
  input  logic             retire,
  input  logic             mode_ext,
  input  logic [AW-1:0]    laddr,
  input  logic [PW-1:0]    pg_reg0,
  input  logic [PW-1:0]    pg_reg1,
  input  logic [PW-1:0]    pg_reg2,
  input  logic [PW-1:0]    pg_reg3,
  input  logic             trap_b,
  output logic [PW+AW-3:0] paddr,
  output logic             lock
);
  localparam int OW = AW - 2;
  localparam int NW = CW + 1;

  logic [NW-1:0] cnt;
  logic [PW-1:0] ovr_page;
  logic [PW-1:0] reg_page;
  logic          active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ovr_page <= '0;
    end else if (trap_b) begin
      cnt <= '0;
    end else if (issue) begin
      cnt      <= {1'b0, issue_len} + NW'(1);
      ovr_page <= issue_page;
    end else if (retire && cnt != '0) begin
      cnt <= cnt - NW'(1);
    end
  end

  always_comb begin
    case (laddr[AW-1:AW-2])
      2'd0:    reg_page = pg_reg0;
      2'd1:    reg_page = pg_reg1;
      2'd2:    reg_page = pg_reg2;
      default: reg_page = pg_reg3;
    endcase
  end

  assign active = (cnt != '0) && !trap_b;
  assign lock   = active;
  assign paddr  = {(active && mode_ext) ? ovr_page : reg_page, laddr[OW-1:0]};
endmodule

module page_override_chk #(
  parameter int PW = 10,
  parameter int AW = 16,
  parameter int CW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic [CW-1:0]    issue_len,
  input logic             retire,
  input logic             trap_b,
  input logic [AW-1:0]    laddr,
  input logic [PW+AW-3:0] paddr,
  input logic             lock,
  input logic [CW:0]      cnt
);
  AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !trap_b) |=> (cnt == {1'b0, $past(issue_len)} + (CW+1)'(1))); // R3
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !trap_b && retire && cnt != '0) |=> (cnt == $past(cnt) - (CW+1)'(1))); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !trap_b && !retire) |=> $stable(cnt)); // R5
  AST_TRAP_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_b |-> !lock); // R7
  AST_TRAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_b |=> (cnt == '0)); // R7
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    paddr[AW-3:0] == laddr[AW-3:0]); // R2
  AST_IDLE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !issue && retire) |=> (cnt == '0) && !lock); // R8
endmodule

bind page_override_unit page_override_chk #(.PW(PW), .AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue(issue), .issue_len(issue_len), .retire(retire),
  .trap_b(trap_b), .laddr(laddr), .paddr(paddr), .lock(lock), .cnt(cnt)
);

// File: tb/page_override_unit_tb.sv
`timescale 1ns/1ps
module page_override_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [9:0]  issue_page = '0;
  logic [1:0]  issue_len = '0;
  logic        retire = 1'b0;
  logic        mode_ext = 1'b0;
  logic [15:0] laddr = '0;
  logic [9:0]  pg [4];
  logic        trap_b = 1'b0;
  logic [23:0] paddr;
  logic        lock;

  int checks = 0;
  int failures = 0;
  int m_cnt = 0;
  logic [9:0] m_page = '0;

  always #2.5 clk = ~clk;

  page_override_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_page(issue_page), .issue_len(issue_len),
    .retire(retire), .mode_ext(mode_ext), .laddr(laddr),
    .pg_reg0(pg[0]), .pg_reg1(pg[1]), .pg_reg2(pg[2]), .pg_reg3(pg[3]),
    .trap_b(trap_b), .paddr(paddr), .lock(lock)
  );

  task automatic chk(input string tag, input logic [23:0] act_a, input logic [23:0] exp_a,
                     input logic act_l, input logic exp_l);
    checks++;
    if (act_a !== exp_a || act_l !== exp_l) begin
      failures++;
      $display("FAIL %s paddr=%h lock=%b expected paddr=%h lock=%b", tag, act_a, act_l, exp_a, exp_l);
    end
  endtask

  // Apply one cycle of stimulus, check combinational outputs, then advance the model.
  task automatic cyc(input string tag, input logic iss, input logic [9:0] pgv, input logic [1:0] ln,
                     input logic ret, input logic tb, input logic ext, input logic [15:0] la);
    logic        act;
    logic [23:0] ea;
    issue = iss; issue_page = pgv; issue_len = ln; retire = ret;
    trap_b = tb; mode_ext = ext; laddr = la;
    #1;
    act = (m_cnt != 0) && !tb;
    ea = {(act && ext) ? m_page : pg[la[15:14]], la[13:0]};
    chk(tag, paddr, ea, lock, act);
    @(posedge clk);
    if (tb) m_cnt = 0;
    else if (iss) begin m_cnt = int'(ln) + 1; m_page = pgv; end
    else if (ret && m_cnt != 0) m_cnt = m_cnt - 1;
    #1;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pg[0] = 10'h015; pg[1] = 10'h0A3; pg[2] = 10'h2C7; pg[3] = 10'h3F0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, all selectors
    for (int q = 0; q < 4; q++) begin
      laddr = {q[1:0], 14'h1A5C}; mode_ext = 1'b1; #0.5;
      chk("R1", paddr, {pg[q], 14'h1A5C}, lock, 1'b0);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R2: idle translation, both modes, all quadrants
    for (int q = 0; q < 4; q++)
      for (int e = 0; e < 2; e++)
        cyc("R2", 1'b0, 10'h0, 2'd0, 1'b0, 1'b0, e[0], {q[1:0], 14'h0333 + 14'(q * 97)});
    // R3 R5 R6 R4: all lengths, several pages
    for (int ln = 0; ln < 4; ln++) begin
      for (int p = 0; p < 3; p++) begin
        cyc("R3", 1'b1, 10'(37 + p * 331 + ln * 5), ln[1:0], 1'b0, 1'b0, 1'b1, 16'h4001);
        for (int k = 0; k <= ln; k++) begin
          cyc("R3", 1'b0, 10'h0, 2'd0, 1'b0, 1'b0, 1'b1, {k[1:0], 14'h2222});
          cyc("R4", 1'b0, 10'h0, 2'd0, 1'b0, 1'b0, 1'b0, {2'(3 - k), 14'h0F0F});
          cyc("R5", 1'b0, 10'h0, 2'd0, 1'b1, 1'b0, 1'b1, {k[1:0], 14'h3ABC});
        end
        cyc("R6", 1'b0, 10'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'hC123);
      end
    end
    // R8: retire in issue cycle does not count
    cyc("R8", 1'b1, 10'h155, 2'd0, 1'b1, 1'b0, 1'b1, 16'h0000);
    cyc("R8", 1'b0, 10'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'h8888);
    cyc("R8", 1'b0, 10'h0, 2'd0, 1'b1, 1'b0, 1'b1, 16'h8888);
    cyc("R8", 1'b0, 10'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'h8888);
    // R8: idle retire has no effect
    for (int i = 0; i < 3; i++) cyc("R8", 1'b0, 10'h0, 2'd0, 1'b1, 1'b0, 1'b1, 16'h5555);
    // R7: trap mid-sequence
    cyc("R7", 1'b1, 10'h2AA, 2'd3, 1'b0, 1'b0, 1'b1, 16'h0);
    cyc("R7", 1'b0, 10'h0, 2'd0, 1'b1, 1'b0, 1'b1, 16'h1234);
    cyc("R7", 1'b0, 10'h0, 2'd0, 1'b0, 1'b1, 1'b1, 16'h1234);
    cyc("R7", 1'b0, 10'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'h1234);
    // R7: trap beats issue
    cyc("R7", 1'b1, 10'h0F1, 2'd2, 1'b0, 1'b1, 1'b1, 16'h0);
    cyc("R7", 1'b0, 10'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'hF00D);
    // R9: reissue reloads page and count
    cyc("R9", 1'b1, 10'h111, 2'd0, 1'b0, 1'b0, 1'b1, 16'h0);
    cyc("R9", 1'b1, 10'h222, 2'd1, 1'b0, 1'b0, 1'b1, 16'h7777);
    for (int i = 0; i < 3; i++) cyc("R9", 1'b0, 10'h0, 2'd0, 1'b1, 1'b0, 1'b1, 16'hABCD);
    cyc("R9", 1'b0, 10'h0, 2'd0, 1'b0, 1'b0, 1'b1, 16'hABCD);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule